// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a store pipeline and a memory write port. It takes stores of one 64-bit word at a time and gathers them, by cache line, into a small set of line buffers. Each buffer covers one 32-byte line, held as four words, and each word has its own valid bit. Stores are taken in at once. The memory write comes later, as one transfer that carries the line address, all four words and a word mask.

A buffer is sent to memory when all four of its words have been written. The block also keeps one buffer ready for a new line. A store that takes the last free buffer forces the oldest partially filled buffer out early, with a mask that covers only its valid words. Buffers waiting for the memory port go out in the order they were allocated. A buffer returns to the free pool only when the memory port accepts it.

Top module: `wcb_store_buffer`

## Requirements
- R1: `st_ready` is high when a filling buffer already holds the store's line or when at least one buffer is free. It is low when neither is true, and then no store is taken.
- R2: The line address is `st_addr[ADDR_W-1:5]` and the word index is `st_addr[4:3]`. A store to a line held by a filling buffer merges into that buffer. It does not take a new buffer.
- R3: A second store to a word that is already valid in a filling buffer replaces the earlier data of that word.
- R4: On the memory port, mask bit i and `mem_data[64*i+63:64*i]` belong to word i. A line whose four words are all written is sent with mask 4'b1111.
- R5: A store that allocates the last free buffer makes the oldest other filling buffer flush. That flush carries a mask of exactly that buffer's valid words.
- R6: Buffers waiting for the memory port are sent oldest allocation first. Each line is written to memory exactly once.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_line`, `mem_data` and `mem_mask` hold their values.
- R8: After reset, `st_ready` is high and `mem_valid` is low. A partially filled buffer is never written to memory unless a flush is triggered.
- R9: `mem_mask` is never all zero while `mem_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Byte address of the store word |
| st_data | input | DATA_W | Store word |
| mem_valid | output | 1 | Line write present |
| mem_ready | input | 1 | Memory takes the line write |
| mem_line | output | ADDR_W-5 | Line address of the write |
| mem_data | output | 4*DATA_W | Four words of the line, word 0 in the low bits |
| mem_mask | output | 4 | Valid words of the write |

## Verification
The bound checker watches on every cycle that a stalled memory write holds steady and that its mask is never empty. It also checks that the store side stalls only when every buffer is occupied, and that no two filling buffers ever hold the same line. Merge and overwrite of words, the early flush of the oldest partial line when the last buffer is taken, the allocation order of writes under back-pressure, and the holding of an untriggered partial line can only be shown by the bench's scenarios. These are compared item by item against a scoreboard.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

   typedef enum logic [1:0] {
      BUF_FREE = 2'd0,
      BUF_FILL = 2'd1,
      BUF_PEND = 2'd2
   } buf_state_e;

endpackage

// File: rtl/wcb_line_buf.sv
module wcb_line_buf #(
   parameter int DATA_W = 64,
   parameter int WORDS  = 4,
   parameter int LINE_W = 27
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_i,
   input  logic                    write_i,
   input  logic [$clog2(WORDS)-1:0] word_i,
   input  logic [DATA_W-1:0]       data_i,
   input  logic [LINE_W-1:0]       line_i,
   input  logic                    evict_i,
   input  logic                    release_i,
   output wcb_pkg::buf_state_e     state_o,
   output logic [LINE_W-1:0]       line_o,
   output logic [WORDS*DATA_W-1:0] data_o,
   output logic [WORDS-1:0]        valid_o
);
   import wcb_pkg::*;

   localparam int IDX_W = $clog2(WORDS);

   buf_state_e                   state_q;
   logic [LINE_W-1:0]            line_q;
   logic [WORDS-1:0]             valid_q;
   logic [WORDS-1:0][DATA_W-1:0] data_q;
   logic [WORDS-1:0]             word_bit;
   logic [WORDS-1:0]             merged;
   logic                         we;

   assign word_bit = WORDS'(1) << word_i;
   assign we       = alloc_i | write_i;
   assign merged   = alloc_i ? word_bit : (valid_q | word_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BUF_FREE;
         valid_q <= '0;
         line_q  <= '0;
      end else if (release_i) begin
         state_q <= BUF_FREE;
         valid_q <= '0;
      end else if (we) begin
         valid_q <= merged;
         if (alloc_i) line_q <= line_i;
         state_q <= (&merged) ? BUF_PEND : BUF_FILL;
      end else if (evict_i && state_q == BUF_FILL) begin
         state_q <= BUF_PEND;
      end
   end

   always_ff @(posedge clk) begin
      for (int w = 0; w < WORDS; w++) begin
         if (we && word_i == IDX_W'(w)) data_q[w] <= data_i;
      end
   end

   assign state_o = state_q;
   assign line_o  = line_q;
   assign valid_o = valid_q;
   assign data_o  = data_q;

endmodule

// File: rtl/wcb_age_order.sv
module wcb_age_order #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] alloc_vec,
   input  logic [N-1:0] cand_a,
   output logic [N-1:0] pick_a,
   input  logic [N-1:0] cand_b,
   output logic [N-1:0] pick_b
);
   // older_q[i][j] set: buffer i was allocated before buffer j
   logic [N-1:0] older_q [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               older_q[i][j] <= (i < j);
      end else begin
         for (int k = 0; k < N; k++) begin
            if (alloc_vec[k]) begin
               for (int j = 0; j < N; j++) begin
                  if (j != k) begin
                     older_q[k][j] <= 1'b0;
                     older_q[j][k] <= 1'b1;
                  end
               end
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         pick_a[i] = cand_a[i];
         pick_b[i] = cand_b[i];
         for (int j = 0; j < N; j++) begin
            if (j != i && cand_a[j] && !older_q[i][j]) pick_a[i] = 1'b0;
            if (j != i && cand_b[j] && !older_q[i][j]) pick_b[i] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/wcb_store_buffer.sv
module wcb_store_buffer #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64,
   parameter int WORDS   = 4,
   parameter int NUM_BUF = 4
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         st_valid,
   output logic                                         st_ready,
   input  logic [ADDR_W-1:0]                            st_addr,
   input  logic [DATA_W-1:0]                            st_data,
   output logic                                         mem_valid,
   input  logic                                         mem_ready,
   output logic [ADDR_W-$clog2(WORDS*DATA_W/8)-1:0]     mem_line,
   output logic [WORDS*DATA_W-1:0]                      mem_data,
   output logic [WORDS-1:0]                             mem_mask
);
   import wcb_pkg::*;

   localparam int IDX_W     = $clog2(WORDS);
   localparam int BYTE_W    = $clog2(DATA_W / 8);
   localparam int OFF_W     = IDX_W + BYTE_W;
   localparam int LINE_W    = ADDR_W - OFF_W;
   localparam int LINE_BITS = WORDS * DATA_W;
   localparam int BUF_W     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

   generate
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("WORDS must be a power of two of at least 2");
      end
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("DATA_W must be a power of two of at least 8");
      end
      if (NUM_BUF < 2) begin : g_bad_bufs
         $error("NUM_BUF must be at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W too small for the line size");
      end
   endgenerate

   // store address split
   logic [LINE_W-1:0] st_line;
   logic [IDX_W-1:0]  st_word;
   logic              addr_unused;
   assign st_line     = st_addr[ADDR_W-1:OFF_W];
   assign st_word     = st_addr[OFF_W-1:BYTE_W];
   assign addr_unused = ^st_addr[BYTE_W-1:0];

   // per-buffer views
   buf_state_e        buf_state [NUM_BUF];
   logic [LINE_W-1:0] buf_line  [NUM_BUF];
   logic [LINE_BITS-1:0] buf_data [NUM_BUF];
   logic [WORDS-1:0]  buf_valid [NUM_BUF];

   logic [NUM_BUF-1:0] free_vec, fill_vec, pend_vec, occ_vec, hit_vec;
   logic [NUM_BUF-1:0] alloc_pick, alloc_vec, write_vec, evict_vec, release_vec;
   logic [NUM_BUF-1:0] victim_pick, issue_pick;
   logic [NUM_BUF*LINE_W-1:0] line_flat;
   logic hit, accept, rel, last_free, evict_any;

   logic              lock_vld_q;
   logic [BUF_W-1:0]  lock_idx_q;
   logic [BUF_W-1:0]  issue_idx;

   generate
      for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
         assign free_vec[b] = (buf_state[b] == BUF_FREE);
         assign fill_vec[b] = (buf_state[b] == BUF_FILL);
         assign occ_vec[b]  = ~free_vec[b];
         assign hit_vec[b]  = fill_vec[b] && (buf_line[b] == st_line);
         assign pend_vec[b] = (buf_state[b] == BUF_PEND) && !release_vec[b];
         assign line_flat[b*LINE_W +: LINE_W] = buf_line[b];

         wcb_line_buf #(
            .DATA_W (DATA_W),
            .WORDS  (WORDS),
            .LINE_W (LINE_W)
         ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_vec[b]),
            .write_i   (write_vec[b]),
            .word_i    (st_word),
            .data_i    (st_data),
            .line_i    (st_line),
            .evict_i   (evict_vec[b]),
            .release_i (release_vec[b]),
            .state_o   (buf_state[b]),
            .line_o    (buf_line[b]),
            .data_o    (buf_data[b]),
            .valid_o   (buf_valid[b])
         );
      end
   endgenerate

   // lowest-index free buffer for a new line
   always_comb begin
      alloc_pick = '0;
      for (int b = NUM_BUF - 1; b >= 0; b--) begin
         if (free_vec[b]) alloc_pick = NUM_BUF'(1) << b;
      end
   end

   assign hit       = |hit_vec;
   assign st_ready  = hit | (|free_vec);
   assign accept    = st_valid & st_ready;
   assign alloc_vec = (accept && !hit) ? alloc_pick : '0;
   assign write_vec = (accept && hit) ? hit_vec : '0;

   assign rel         = lock_vld_q & mem_ready;
   assign release_vec = rel ? (NUM_BUF'(1) << lock_idx_q) : '0;

   // taking the last free buffer pushes the oldest partial line out
   assign last_free = ($countones(free_vec) == 1);
   assign evict_any = (|alloc_vec) && last_free && !rel;
   assign evict_vec = evict_any ? victim_pick : '0;

   wcb_age_order #(.N(NUM_BUF)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_vec (alloc_vec),
      .cand_a    (fill_vec),
      .pick_a    (victim_pick),
      .cand_b    (pend_vec),
      .pick_b    (issue_pick)
   );

   always_comb begin
      issue_idx = '0;
      for (int b = 0; b < NUM_BUF; b++) begin
         if (issue_pick[b]) issue_idx = BUF_W'(b);
      end
   end

   // the issued buffer is latched so the port holds steady under back-pressure
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_vld_q <= 1'b0;
         lock_idx_q <= '0;
      end else if (!lock_vld_q || rel) begin
         lock_vld_q <= |pend_vec;
         lock_idx_q <= issue_idx;
      end
   end

   assign mem_valid = lock_vld_q;
   assign mem_line  = buf_line[lock_idx_q];
   assign mem_data  = buf_data[lock_idx_q];
   assign mem_mask  = buf_valid[lock_idx_q];

endmodule

// File: rtl/wcb_store_buffer_chk.sv
module wcb_store_buffer_chk #(
   parameter int NUM_BUF   = 4,
   parameter int LINE_W    = 27,
   parameter int LINE_BITS = 256,
   parameter int WORDS     = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      st_ready,
   input logic                      mem_valid,
   input logic                      mem_ready,
   input logic [LINE_W-1:0]         mem_line,
   input logic [LINE_BITS-1:0]      mem_data,
   input logic [WORDS-1:0]          mem_mask,
   input logic [NUM_BUF-1:0]        occ_vec,
   input logic [NUM_BUF-1:0]        fill_vec,
   input logic [NUM_BUF*LINE_W-1:0] line_flat
);

   logic dup_line;
   always_comb begin
      dup_line = 1'b0;
      for (int i = 0; i < NUM_BUF; i++)
         for (int j = i + 1; j < NUM_BUF; j++)
            if (fill_vec[i] && fill_vec[j] &&
                line_flat[i*LINE_W +: LINE_W] == line_flat[j*LINE_W +: LINE_W])
               dup_line = 1'b1;
   end

   a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid);

   a_r7_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> $stable(mem_line) && $stable(mem_data) && $stable(mem_mask));

   a_r9_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_mask != '0);

   a_r1_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      !st_ready |-> &occ_vec);

   a_r2_one_line_one_buf: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_line);

endmodule

bind wcb_store_buffer wcb_store_buffer_chk #(
   .NUM_BUF   (NUM_BUF),
   .LINE_W    (LINE_W),
   .LINE_BITS (LINE_BITS),
   .WORDS     (WORDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_ready  (st_ready),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_line  (mem_line),
   .mem_data  (mem_data),
   .mem_mask  (mem_mask),
   .occ_vec   (occ_vec),
   .fill_vec  (fill_vec),
   .line_flat (line_flat)
);

// File: tb/tb_wcb_store_buffer.sv
module tb_wcb_store_buffer;

   localparam int ADDR_W = 32;
   localparam int DATA_W = 64;
   localparam int WORDS  = 4;
   localparam int LINE_W = 27;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     st_valid = 1'b0;
   logic                     st_ready;
   logic [ADDR_W-1:0]        st_addr = '0;
   logic [DATA_W-1:0]        st_data = '0;
   logic                     mem_valid;
   logic                     mem_ready = 1'b1;
   logic [LINE_W-1:0]        mem_line;
   logic [WORDS*DATA_W-1:0]  mem_data;
   logic [WORDS-1:0]         mem_mask;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   typedef struct {
      logic [LINE_W-1:0]       line;
      logic [WORDS-1:0]        mask;
      logic [WORDS*DATA_W-1:0] data;
      string                   req;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;

   wcb_store_buffer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_valid  (st_valid),
      .st_ready  (st_ready),
      .st_addr   (st_addr),
      .st_data   (st_data),
      .mem_valid (mem_valid),
      .mem_ready (mem_ready),
      .mem_line  (mem_line),
      .mem_data  (mem_data),
      .mem_mask  (mem_mask)
   );

   function automatic logic [ADDR_W-1:0] mk(int line, int w);
      return {LINE_W'(line), 2'(w), 3'b000};
   endfunction

   function automatic logic [DATA_W-1:0] dv(int line, int w, int tag);
      return {16'(tag), 24'h0, 16'(line), 8'(w)};
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic do_store(int line, int w, int tag);
      st_valid = 1'b1;
      st_addr  = mk(line, w);
      st_data  = dv(line, w, tag);
      #1;
      while (!st_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   // driver side of the scoreboard: expected line write
   task automatic expect_line(int line, logic [WORDS-1:0] mask, int tag0, int tag1,
                              int tag2, int tag3, string req);
      exp_t e;
      int tg [4];
      tg[0] = tag0; tg[1] = tag1; tg[2] = tag2; tg[3] = tag3;
      e.line = LINE_W'(line);
      e.mask = mask;
      e.data = '0;
      for (int w = 0; w < WORDS; w++) e.data[w*DATA_W +: DATA_W] = dv(line, w, tg[w]);
      e.req = req;
      sb.push_back(e);
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 400 && sb.size() != 0; i++) @(negedge clk);
      check(sb.size() == 0, "R6", "drain left items", sb.size(), 0);
      repeat (3) @(negedge clk);
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      #2;
      if (rst_n && mem_valid && mem_ready) begin
         if (sb.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R6 unexpected write line=%0h mask=%0h expected=none", mem_line, mem_mask);
         end else begin
            exp_t e;
            bit ok;
            e = sb.pop_front();
            ok = (mem_line == e.line) && (mem_mask == e.mask);
            for (int w = 0; w < WORDS; w++)
               if (e.mask[w] && mem_data[w*DATA_W +: DATA_W] != e.data[w*DATA_W +: DATA_W])
                  ok = 1'b0;
            checks++;
            if (!ok) begin
               errors++;
               $display("FAIL %s write actual line=%0h mask=%0h expected line=%0h mask=%0h",
                        e.req, mem_line, mem_mask, e.line, e.mask);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R8 reset state
      check(st_ready == 1'b1, "R8", "st_ready after reset", st_ready, 1);
      check(mem_valid == 1'b0, "R8", "mem_valid after reset", mem_valid, 0);

      // R2 R4: full line written out of order, word positions in the mask and data
      expect_line(16, 4'b1111, 1, 1, 1, 1, "R4");
      do_store(16, 2, 1);
      do_store(16, 0, 1);
      do_store(16, 3, 1);
      do_store(16, 1, 1);
      wait_drain();

      // R3: repeated word keeps the latest value
      expect_line(17, 4'b1111, 2, 5, 2, 2, "R3");
      do_store(17, 1, 4);
      do_store(17, 1, 5);
      do_store(17, 0, 2);
      do_store(17, 2, 2);
      do_store(17, 3, 2);
      wait_drain();

      // R5: fourth line evicts oldest partial with its own mask, R6 order after
      expect_line(32, 4'b0100, 3, 3, 3, 3, "R5");
      expect_line(33, 4'b1111, 3, 3, 3, 3, "R6");
      expect_line(34, 4'b1111, 3, 3, 3, 3, "R6");
      expect_line(35, 4'b1111, 3, 3, 3, 3, "R6");
      do_store(32, 2, 3);
      do_store(33, 0, 3);
      do_store(34, 3, 3);
      do_store(35, 1, 3);
      do_store(33, 1, 3);
      do_store(33, 2, 3);
      do_store(33, 3, 3);
      do_store(34, 0, 3);
      do_store(34, 1, 3);
      do_store(34, 2, 3);
      do_store(35, 0, 3);
      do_store(35, 2, 3);
      do_store(35, 3, 3);
      wait_drain();

      // R1 R6 R7: back-pressure with all buffers pending
      mem_ready = 1'b0;
      for (int l = 48; l < 52; l++) expect_line(l, 4'b1111, 6, 6, 6, 6, "R6");
      expect_line(52, 4'b1111, 7, 7, 7, 7, "R1");
      for (int l = 48; l < 52; l++)
         for (int w = 0; w < WORDS; w++) do_store(l, w, 6);
      st_valid = 1'b1;
      st_addr  = mk(52, 0);
      st_data  = dv(52, 0, 7);
      repeat (3) @(negedge clk);
      #1;
      check(st_ready == 1'b0, "R1", "st_ready with all buffers pending", st_ready, 0);
      check(mem_valid == 1'b1, "R7", "mem_valid held", mem_valid, 1);
      check(mem_line == LINE_W'(48), "R6", "oldest line presented", mem_line, 48);
      mem_ready = 1'b1;
      do_store(52, 0, 7);
      do_store(52, 1, 7);
      do_store(52, 2, 7);
      do_store(52, 3, 7);
      wait_drain();

      // R8: an untriggered partial line stays inside
      mem_ready = 1'b0;
      do_store(64, 1, 9);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         #1;
         check(mem_valid == 1'b0, "R8", "partial line held", mem_valid, 0);
      end
      mem_ready = 1'b1;
      expect_line(64, 4'b1111, 9, 9, 9, 9, "R8");
      do_store(64, 0, 9);
      do_store(64, 2, 9);
      do_store(64, 3, 9);
      wait_drain();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule